// File: doc/BRIEF.md
# GPIO Interrupt-on-Change Capture Unit

This block holds the interrupt logic of an eight-pin general-purpose I/O port. Each clock cycle it looks at the already synchronized input pins. It can invert any of them first, and then compares each enabled pin against a reference. In change mode the reference is the pin's last seen level. In level mode the reference is a programmable default bit.

When a pin trips, the unit becomes pending. It records only the lowest-numbered triggering pin in a one-hot flag register and freezes a snapshot of the whole port. It then drives one interrupt line, which can be push-pull of either polarity or open-drain. Software reaches the block through a small register port, and a read strobe marks read accesses. The pending state ends only when a read strobe hits a chosen register: the live port register by default, or the snapshot register when a configuration bit selects it.

While the unit is pending, nothing new is flagged or captured, and the change-mode reference stays at the snapshot. A change that happened during that time therefore raises a fresh interrupt in the cycle right after the clear.

Top module: `gpio_ioc_unit`

## Requirements
- R1: After reset every register reads 0, and the enable register (address 0) is 0. A pin whose enable bit is 0 never makes the unit pending.
- R2: A pin whose enable bit is 1 and whose mode bit (address 1) is 0 makes the unit pending at the clock edge that ends the first idle cycle in which its level differs from its level in the previous cycle. No interrupt follows while levels are steady.
- R3: A pin whose enable bit is 1 and whose mode bit is 1 makes the unit pending while its level differs from its default bit (address 2). If the mismatch remains after a clear, the unit becomes pending again in the next cycle.
- R4: While pending, the flag register (address 5, read-only) holds exactly one set bit. That bit belongs to the lowest-numbered pin that triggered in the cycle the interrupt was raised.
- R5: The snapshot register (address 6, read-only) loads the whole port value at the edge where the unit becomes pending. It holds that value until the next interrupt is raised.
- R6: A read strobe (rd_en=1) at address 7 clears the pending state at the next edge. When configuration bit 2 (address 4) is 1, a read strobe at address 6 clears it instead, and a read of address 7 does not.
- R7: When configuration bit 1 is 0, irq_oe is 1. irq_o equals the pending state when configuration bit 0 is 1, and its inverse when configuration bit 0 is 0.
- R8: When configuration bit 1 is 1 (open-drain), irq_o is 0 and irq_oe equals the pending state, whatever the value of bit 0.
- R9: The input-polarity register (address 3) XORs each pin before both the live port register (address 7) and the compare logic.
- R10: While pending, the flag and snapshot registers do not change. A change-mode pin whose level differs from the snapshot at the clear raises a new interrupt in the next cycle.
- R11: The flag register reads 0 whenever the unit is not pending.
- R12: Registers 0 to 4 are written by wr_en with wdata at the next edge and read back on rdata, with the value combinational from addr. The configuration register uses bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Synchronized input pins |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clearing reads) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| irq_o | output | 1 | Interrupt output level |
| irq_oe | output | 1 | Interrupt output drive enable |

## Verification
Directed cases use several stimuli: two pins changing together, to show that the lowest pin wins the flag; a change made while pending, to separate the frozen snapshot from the live port and to show the re-raise after the clear; and a held level mismatch, to separate level mode from change mode. Separate sequences toggle the clear-select bit and the input inversion, which show which register's read ends the interrupt and whether inversion also reaches the comparator. A long constrained-random phase then mixes pin noise, configuration writes and strobed reads of every address against a cycle model, so that simultaneous triggers, clears and reconfiguration overlap.

// File: rtl/ioc_pkg.sv
package ioc_pkg;
  localparam int ADDR_W = 3;
  localparam int CFG_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_ENA  = 3'd0,
    REG_MODE = 3'd1,
    REG_DFLT = 3'd2,
    REG_IPOL = 3'd3,
    REG_CFG  = 3'd4,
    REG_FLAG = 3'd5,
    REG_CAP  = 3'd6,
    REG_PORT = 3'd7
  } reg_addr_e;

  // bit 0 act_high, bit 1 open_drain, bit 2 clr_on_cap
  typedef struct packed {
    logic clr_on_cap;
    logic open_drain;
    logic act_high;
  } cfg_t;
endpackage

// File: rtl/ioc_cfg_regs.sv
module ioc_cfg_regs
  import ioc_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPIN-1:0]   wdata,
  output logic [NPIN-1:0]   ena,
  output logic [NPIN-1:0]   mode,
  output logic [NPIN-1:0]   dflt,
  output logic [NPIN-1:0]   ipol,
  output cfg_t              cfg
);
  logic [NPIN-1:0] ena_d, mode_d, dflt_d, ipol_d;
  cfg_t            cfg_d;

  always_comb begin
    ena_d  = ena;
    mode_d = mode;
    dflt_d = dflt;
    ipol_d = ipol;
    cfg_d  = cfg;
    if (wr_en) begin
      unique case (addr)
        REG_ENA:  ena_d  = wdata;
        REG_MODE: mode_d = wdata;
        REG_DFLT: dflt_d = wdata;
        REG_IPOL: ipol_d = wdata;
        REG_CFG:  cfg_d  = cfg_t'(wdata[CFG_W-1:0]);
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena  <= '0;
      mode <= '0;
      dflt <= '0;
      ipol <= '0;
      cfg  <= '0;
    end else begin
      ena  <= ena_d;
      mode <= mode_d;
      dflt <= dflt_d;
      ipol <= ipol_d;
      cfg  <= cfg_d;
    end
  end

  // R12: a write lands in the addressed register at the next edge
  a_r12_ena_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_ENA) |=> (ena == $past(wdata)));
endmodule

// File: rtl/ioc_detect.sv
module ioc_detect #(
  parameter int NPIN = 8
) (
  input  logic [NPIN-1:0] port_v,
  input  logic [NPIN-1:0] last,
  input  logic [NPIN-1:0] ena,
  input  logic [NPIN-1:0] mode,
  input  logic [NPIN-1:0] dflt,
  output logic [NPIN-1:0] trig,
  output logic [NPIN-1:0] first,
  output logic            trig_any
);
  logic [NPIN:0] seen;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    assign trig[i]    = ena[i] & (mode[i] ? (port_v[i] ^ dflt[i])
                                          : (port_v[i] ^ last[i]));
    assign first[i]   = trig[i] & ~seen[i];
    assign seen[i+1]  = seen[i] | trig[i];
  end

  assign trig_any = seen[NPIN];

  // R4: the chosen pin is a single triggering pin with no lower trigger
  always_comb begin
    if (trig_any) begin
      a_r4_lowest_pin: assert ($countones(first) == 1 &&
                               (first & ~trig) == '0 &&
                               ((first - 1'b1) & trig) == '0);
    end
  end
endmodule

// File: rtl/ioc_capture.sv
module ioc_capture #(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] port_v,
  input  logic            trig_any,
  input  logic [NPIN-1:0] first,
  input  logic            clr,
  output logic            pending,
  output logic [NPIN-1:0] flag,
  output logic [NPIN-1:0] cap,
  output logic [NPIN-1:0] last
);
  logic            pend_d;
  logic [NPIN-1:0] flag_d, cap_d, last_d;

  always_comb begin
    pend_d = pending;
    flag_d = flag;
    cap_d  = cap;
    last_d = last;
    if (!pending) begin
      last_d = port_v;
      if (trig_any) begin
        pend_d = 1'b1;
        flag_d = first;
        cap_d  = port_v;
      end
    end else if (clr) begin
      pend_d = 1'b0;
      flag_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      flag    <= '0;
      cap     <= '0;
      last    <= '0;
    end else begin
      pending <= pend_d;
      flag    <= flag_d;
      cap     <= cap_d;
      last    <= last_d;
    end
  end

  // R4: one flag bit while pending
  a_r4_flag_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> ($countones(flag) == 1));
  // R11: flag empty while idle
  a_r11_flag_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |-> (flag == '0));
  // R5 / R10: snapshot and flag frozen while pending
  a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !clr) |=> ($stable(cap) && $stable(flag) && pending));
  // R6: a clearing read ends the pending state
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && clr) |=> !pending);
  // R5: snapshot equals the port value at the raising edge
  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && trig_any) |=> (cap == $past(port_v)));
endmodule

// File: rtl/ioc_irq_drive.sv
module ioc_irq_drive (
  input  logic pending,
  input  logic act_high,
  input  logic open_drain,
  output logic irq_o,
  output logic irq_oe
);
  always_comb begin
    if (open_drain) begin
      irq_o  = 1'b0;
      irq_oe = pending;
    end else begin
      irq_o  = act_high ? pending : ~pending;
      irq_oe = 1'b1;
    end
  end

  // R8: open-drain never drives high
  always_comb begin
    if (open_drain) begin
      a_r8_no_high: assert (!(irq_oe && irq_o));
    end
  end
endmodule

// File: rtl/gpio_ioc_unit.sv
module gpio_ioc_unit
  import ioc_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   pin_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPIN-1:0]   wdata,
  output logic [NPIN-1:0]   rdata,
  output logic              irq_o,
  output logic              irq_oe
);
  localparam int PADW = NPIN - CFG_W;

  logic [NPIN-1:0] ena, mode, dflt, ipol;
  cfg_t            cfg;
  logic [NPIN-1:0] port_v, trig, first, flag, cap, last;
  logic            trig_any, pending, clr;

  ioc_cfg_regs #(.NPIN(NPIN)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ena(ena), .mode(mode), .dflt(dflt), .ipol(ipol), .cfg(cfg)
  );

  assign port_v = pin_i ^ ipol;

  ioc_detect #(.NPIN(NPIN)) u_det (
    .port_v(port_v), .last(last), .ena(ena), .mode(mode), .dflt(dflt),
    .trig(trig), .first(first), .trig_any(trig_any)
  );

  assign clr = rd_en && (cfg.clr_on_cap ? (addr == REG_CAP)
                                        : (addr == REG_PORT));

  ioc_capture #(.NPIN(NPIN)) u_cap (
    .clk(clk), .rst_n(rst_n), .port_v(port_v), .trig_any(trig_any),
    .first(first), .clr(clr), .pending(pending), .flag(flag),
    .cap(cap), .last(last)
  );

  ioc_irq_drive u_drv (
    .pending(pending), .act_high(cfg.act_high), .open_drain(cfg.open_drain),
    .irq_o(irq_o), .irq_oe(irq_oe)
  );

  always_comb begin
    unique case (addr)
      REG_ENA:  rdata = ena;
      REG_MODE: rdata = mode;
      REG_DFLT: rdata = dflt;
      REG_IPOL: rdata = ipol;
      REG_CFG:  rdata = {{PADW{1'b0}}, cfg};
      REG_FLAG: rdata = flag;
      REG_CAP:  rdata = cap;
      default:  rdata = port_v;
    endcase
  end

  // R1: with nothing enabled an idle unit stays idle
  a_r1_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ena == '0 && !pending) |=> !pending);
  // R7: push-pull output follows pending with the chosen polarity
  a_r7_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.open_drain |-> (irq_oe && (irq_o == (cfg.act_high ~^ pending))));
  // R10: a mismatch against the snapshot right after a clear re-raises
  a_r10_reraise: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && $past(pending) && ((ena & ~mode & (port_v ^ cap)) != '0))
      |=> pending);
endmodule

// File: tb/tb_gpio_ioc_unit.sv
`timescale 1ns/1ps
module tb_gpio_ioc_unit;
  localparam int NPIN = 8;
  localparam logic [2:0] A_ENA = 3'd0, A_MODE = 3'd1, A_DFLT = 3'd2,
    A_IPOL = 3'd3, A_CFG = 3'd4, A_FLAG = 3'd5, A_CAP = 3'd6, A_PORT = 3'd7;

  logic clk, rst_n, wr_en, rd_en, irq_o, irq_oe;
  logic [2:0] addr;
  logic [NPIN-1:0] pin_i, wdata, rdata, v;
  int nchk, nfail, cyc;

  gpio_ioc_unit #(.NPIN(NPIN)) dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .irq_oe(irq_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // cycle model built from the requirements
  logic [NPIN-1:0] m_ena, m_mode, m_dflt, m_ipol, m_flag, m_cap, m_last;
  logic [2:0] m_cfg;
  logic m_pend;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ena = '0; m_mode = '0; m_dflt = '0; m_ipol = '0; m_cfg = '0;
      m_flag = '0; m_cap = '0; m_last = '0; m_pend = 1'b0;
    end else begin
      logic [NPIN-1:0] pv, tr;
      logic clr;
      pv  = pin_i ^ m_ipol;
      clr = rd_en && (m_cfg[2] ? (addr == A_CAP) : (addr == A_PORT));
      if (!m_pend) begin
        tr = m_ena & ((~m_mode & (pv ^ m_last)) | (m_mode & (pv ^ m_dflt)));
        if (tr != '0) begin
          m_pend = 1'b1;
          m_flag = tr & (~tr + 1'b1);
          m_cap  = pv;
        end
        m_last = pv;
      end else if (clr) begin
        m_pend = 1'b0;
        m_flag = '0;
      end
      if (wr_en) begin
        case (addr)
          A_ENA:  m_ena  = wdata;
          A_MODE: m_mode = wdata;
          A_DFLT: m_dflt = wdata;
          A_IPOL: m_ipol = wdata;
          A_CFG:  m_cfg  = wdata[2:0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [NPIN-1:0] model_read(input logic [2:0] a);
    case (a)
      A_ENA:  return m_ena;
      A_MODE: return m_mode;
      A_DFLT: return m_dflt;
      A_IPOL: return m_ipol;
      A_CFG:  return {5'd0, m_cfg};
      A_FLAG: return m_flag;
      A_CAP:  return m_cap;
      default: return pin_i ^ m_ipol;
    endcase
  endfunction

  function automatic logic [1:0] model_irq(input logic p, input logic [2:0] c);
    if (c[1]) return {p, 1'b0};
    return {1'b1, c[0] ? p : ~p};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [NPIN-1:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [NPIN-1:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    tick();
    rd_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nchk++; nfail++;
      $display("FAIL watchdog got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    nchk = 0; nfail = 0; cyc = 0;
    pin_i = '0;
    do_reset();
    // R7 reset state: active-low push-pull idle high
    chk("R7 reset irq", {irq_oe, irq_o}, 2'b11);
    rd(A_FLAG, v); chk("R11 reset flag", v, 8'h00);
    rd(A_ENA, v);  chk("R1 reset enable", v, 8'h00);
    // R1: pins move, nothing enabled
    pin_i = 8'hFF; tick(); tick();
    chk("R1 disabled pins", irq_o, 1'b1);
    pin_i = 8'h00; tick(); tick();
    // R2 change mode, two pins at once
    wr(A_ENA, 8'hFF);
    pin_i = 8'h0A; tick();
    chk("R2 change raises", irq_o, 1'b0);
    rd(A_FLAG, v); chk("R4 lowest pin flag", v, 8'h02);
    rd(A_CAP, v);  chk("R5 capture", v, 8'h0A);
    pin_i = 8'h0B; tick();
    rd(A_CAP, v);  chk("R5 capture frozen", v, 8'h0A);
    rd(A_FLAG, v); chk("R10 flag frozen", v, 8'h02);
    rd(A_PORT, v); chk("R9 live port", v, 8'h0B);
    chk("R6 port read clears", irq_o, 1'b1);
    tick();
    chk("R10 re-raise after clear", irq_o, 1'b0);
    rd(A_FLAG, v); chk("R10 new flag", v, 8'h01);
    rd(A_CAP, v);  chk("R5 new capture", v, 8'h0B);
    rd(A_PORT, v);
    chk("R6 cleared", irq_o, 1'b1);
    tick();
    chk("R2 steady no irq", irq_o, 1'b1);
    // R6 capture-read clear select
    wr(A_CFG, 8'h04);
    pin_i = 8'h1B; tick();
    chk("R2 raise", irq_o, 1'b0);
    rd(A_FLAG, v); chk("R4 flag pin4", v, 8'h10);
    rd(A_PORT, v); chk("R6 port read keeps", irq_o, 1'b0);
    rd(A_CAP, v);  chk("R6 cap read value", v, 8'h1B);
    chk("R6 cap read clears", irq_o, 1'b1);
    // R3 level mode
    wr(A_CFG, 8'h00); wr(A_ENA, 8'h80); wr(A_MODE, 8'h80);
    chk("R3 level match idle", irq_o, 1'b1);
    pin_i = 8'h9B; tick();
    chk("R3 level mismatch", irq_o, 1'b0);
    rd(A_FLAG, v); chk("R3 flag pin7", v, 8'h80);
    rd(A_PORT, v); chk("R6 clear", irq_o, 1'b1);
    tick();
    chk("R3 mismatch re-raises", irq_o, 1'b0);
    wr(A_DFLT, 8'h80);
    rd(A_PORT, v); chk("R6 clear", irq_o, 1'b1);
    tick();
    chk("R3 match stays idle", irq_o, 1'b1);
    // R9 input inversion feeds compare
    wr(A_IPOL, 8'h80); tick();
    chk("R9 inversion triggers", irq_o, 1'b0);
    rd(A_PORT, v); chk("R9 inverted port", v, 8'h1B);
    wr(A_ENA, 8'h00);
    rd(A_PORT, v); chk("R6 clear", irq_o, 1'b1);
    tick();
    chk("R1 disabled idle", irq_o, 1'b1);
    // R7 / R8 output modes
    wr(A_IPOL, 8'h00);
    wr(A_CFG, 8'h01);
    chk("R7 active-high idle", {irq_oe, irq_o}, 2'b10);
    rd(A_CFG, v); chk("R12 cfg readback", v, 8'h01);
    wr(A_CFG, 8'h03);
    chk("R8 open-drain idle", {irq_oe, irq_o}, 2'b00);
    wr(A_MODE, 8'h00); wr(A_ENA, 8'h01);
    pin_i = 8'h1A; tick();
    chk("R8 open-drain pending", {irq_oe, irq_o}, 2'b10);
    rd(A_PORT, v);
    chk("R8 released", {irq_oe, irq_o}, 2'b00);

    // random phase against the cycle model
    do_reset();
    void'($urandom(32'd20240611));
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if ($urandom_range(0, 3) == 0) pin_i = 8'($urandom());
      wr_en = 1'b0; rd_en = 1'b0;
      if (r < 10) begin
        wr_en = 1'b1; addr = 3'($urandom_range(0, 4)); wdata = 8'($urandom());
      end else if (r < 35) begin
        rd_en = 1'b1; addr = 3'($urandom_range(0, 7));
      end
      #1;
      if (rd_en) begin
        case (addr)
          A_FLAG:  chk("R4 random flag", rdata, model_read(addr));
          A_CAP:   chk("R5 random capture", rdata, model_read(addr));
          A_PORT:  chk("R9 random port", rdata, model_read(addr));
          default: chk("R12 random config", rdata, model_read(addr));
        endcase
      end
      if (m_cfg[1]) chk("R8 random irq", {irq_oe, irq_o}, model_irq(m_pend, m_cfg));
      else          chk("R7 random irq", {irq_oe, irq_o}, model_irq(m_pend, m_cfg));
      tick();
    end
    wr_en = 1'b0; rd_en = 1'b0;
    finish_run();
  end
endmodule